// File: doc/BRIEF.md
# Paged Memory Select Decoder

This block sits between an 8-bit microcontroller bus, whose low address byte shares its wires with the data, and the select inputs of a set of on-chip memories. The low address byte and the upper address byte are captured when the address-latch strobe is high. The captured bytes are joined with an 8-bit page register to form a 24-bit extended address, laid out as {page, high byte, low byte}. The block compares that address against a table of programmable windows. From the result it raises at most one of the following selects: a register-window select, eight primary-sector selects, four secondary-sector selects or one SRAM select.

Each select owns up to three windows. A window is a match/mask pair with an enable bit, so one sector can appear at several places in the extended address space. The window table is fixed by parameters. The MCU reads and writes the page register at offset 0xE0 inside the register window. An active-low chip-select input can shut off every select, every read drive and every page write. The block also registers an output enable for the read-data drivers.

Top module: `pgdec_top`

## Requirements
- R1: A synchronous active-high reset clears the page register and both captured address bytes to zero. It also drives every select, `data_oe` and `data_out` to zero.
- R2: On a clock edge where `ale` is 1, `bus_lo_in` and `bus_hi_in` are captured. While `ale` is 0, changes on the bus have no effect on the selects.
- R3: The extended address is {page, captured high byte, captured low byte}, with the page in bits 23:16. Changing only the page changes which select fires.
- R4: With the default table, page 0x00 and high byte 0x00–0x7F select primary sector n, where n is bits 6:4 of the high byte.
- R5: With the default table, page 0x00 and high byte 0x80–0xBF select secondary sector m, where m is bits 5:4 of the high byte.
- R6: With the default table, high byte 0xC0–0xDF selects the SRAM on any page.
- R7: With the default table, high byte 0xFF selects the register window on any page.
- R8: Windows after the first give extra regions. Primary sectors repeat on page 0x01. Primary sector 0 also answers at high byte 0xF0–0xFE on any page. A disabled window never matches, so page 0x02 with a high byte below 0xC0 selects nothing.
- R9: When windows overlap, the order of precedence is: register window, then primary sectors 0 to 7, then secondary sectors 0 to 3, then the SRAM. At most one select is active at a time.
- R10: A write loads the page register from `bus_lo_in` only when all of these hold at a clock edge: the register window is hit, the captured low byte is 0xE0, `wr_n` is 0 and `csel_n` is 0. A write to any other offset leaves the page unchanged.
- R11: A read of register offset 0xE0 returns the page value on `data_out`. At all other times `data_out` is 0x00.
- R12: When `csel_n` is 1, all selects and `data_oe` go to 0 and page writes are blocked.
- R13: `data_oe` is 1 only when `rd_n` was 0, `csel_n` was 0 and some select was hit.
- R14: Selects, `data_oe` and `data_out` are registered. Each reflects the state and inputs of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address-latch strobe, active high |
| bus_lo_in | input | 8 | Multiplexed low address / write data |
| bus_hi_in | input | 8 | Upper address byte |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| csel_n | input | 1 | Block chip select, active low |
| data_out | output | 8 | Register read data |
| data_oe | output | 1 | Read-data drive enable |
| reg_sel | output | 1 | Register-window select |
| prim_sel | output | NPRIM | Primary-sector selects |
| sec_sel | output | NSEC | Secondary-sector selects |
| sram_sel | output | 1 | SRAM select |

## Verification
The bench targets overlap regions: high byte 0xFF, where the register window must win over primary sector 0's third window, and page 0x01 low addresses, where primary sector 0 must win over secondary sector 0. A wrong priority would raise the wrong select or two selects at once. It writes the page at offset 0xE1 and while the chip select is off, and in both cases the page must not change. A decoder that compared the offset wrongly, or that did not gate writes, would move later reads to another page. It also changes the bus during data phases and reads unmapped addresses. A latch that was transparent would make the selects glitch, and a badly gated drive enable would drive the bus with nothing selected.

// File: rtl/pgdec_pkg.sv
package pgdec_pkg;
  localparam int AW        = 24;
  localparam int DEF_NPRIM = 8;
  localparam int DEF_NSEC  = 4;
  localparam int DEF_NWIN  = 3;
  localparam int DEF_NSEL  = DEF_NPRIM + DEF_NSEC + 2;
  localparam int DEF_NENT  = DEF_NSEL * DEF_NWIN;

  typedef struct packed {
    logic          en;
    logic [AW-1:0] match;
    logic [AW-1:0] mask;
  } win_t;

  // select index s: 0 register window, 1..8 primary, 9..12 secondary, 13 SRAM
  function automatic win_t def_win(input int s, input int w);
    win_t r;
    r = '0;
    if (s == 0) begin
      if (w == 0) r = '{1'b1, 24'h00FF00, 24'h00FF00};
    end else if (s <= DEF_NPRIM) begin
      if (w == 0) r = '{1'b1, 24'h000000 | (AW'(s - 1) << 12), 24'hFFF000};
      if (w == 1) r = '{1'b1, 24'h010000 | (AW'(s - 1) << 12), 24'hFFF000};
      if (w == 2 && s == 1) r = '{1'b1, 24'h00F000, 24'h00F000};
    end else if (s <= DEF_NPRIM + DEF_NSEC) begin
      if (w == 0) r = '{1'b1, AW'(8 + s - 1 - DEF_NPRIM) << 12, 24'hFFF000};
      if (w == 1 && s == DEF_NPRIM + 1) r = '{1'b1, 24'h010000, 24'hFFF000};
    end else begin
      if (w == 0) r = '{1'b1, 24'h00C000, 24'h00E000};
    end
    return r;
  endfunction

  function automatic logic [DEF_NENT*AW-1:0] def_match();
    logic [DEF_NENT*AW-1:0] v;
    win_t t;
    v = '0;
    for (int s = 0; s < DEF_NSEL; s++)
      for (int w = 0; w < DEF_NWIN; w++) begin
        t = def_win(s, w);
        v[(s*DEF_NWIN+w)*AW +: AW] = t.match;
      end
    return v;
  endfunction

  function automatic logic [DEF_NENT*AW-1:0] def_mask();
    logic [DEF_NENT*AW-1:0] v;
    win_t t;
    v = '0;
    for (int s = 0; s < DEF_NSEL; s++)
      for (int w = 0; w < DEF_NWIN; w++) begin
        t = def_win(s, w);
        v[(s*DEF_NWIN+w)*AW +: AW] = t.mask;
      end
    return v;
  endfunction

  function automatic logic [DEF_NENT-1:0] def_en();
    logic [DEF_NENT-1:0] v;
    win_t t;
    v = '0;
    for (int s = 0; s < DEF_NSEL; s++)
      for (int w = 0; w < DEF_NWIN; w++) begin
        t = def_win(s, w);
        v[s*DEF_NWIN+w] = t.en;
      end
    return v;
  endfunction
endpackage

// File: rtl/pgdec_latch.sv
module pgdec_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale,
  input  logic [DW-1:0] bus_lo,
  input  logic [DW-1:0] bus_hi,
  input  logic          page_we,
  output logic [DW-1:0] lat_lo,
  output logic [DW-1:0] lat_hi,
  output logic [DW-1:0] page_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_lo <= '0;
      lat_hi <= '0;
      page_q <= '0;
    end else begin
      if (ale) begin
        lat_lo <= bus_lo;
        lat_hi <= bus_hi;
      end
      if (page_we) page_q <= bus_lo;
    end
  end
endmodule

// File: rtl/pgdec_win.sv
module pgdec_win #(
  parameter int                  NWIN  = 3,
  parameter int                  AW    = 24,
  parameter logic [NWIN*AW-1:0]  MATCH = '0,
  parameter logic [NWIN*AW-1:0]  MASK  = '0,
  parameter logic [NWIN-1:0]     EN    = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [NWIN-1:0] term;

  for (genvar w = 0; w < NWIN; w++) begin : g_term
    if (EN[w]) begin : g_on
      assign term[w] = ((addr ^ MATCH[w*AW +: AW]) & MASK[w*AW +: AW]) == '0;
    end else begin : g_off
      assign term[w] = 1'b0;
    end
  end

  assign hit = |term;
endmodule

// File: rtl/pgdec_prio.sv
module pgdec_prio #(
  parameter int N = 14
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pgdec_top.sv
module pgdec_top
  import pgdec_pkg::*;
#(
  parameter int NPRIM = DEF_NPRIM,
  parameter int NSEC  = DEF_NSEC,
  parameter int NWIN  = DEF_NWIN,
  parameter logic [7:0] PAGE_OFS = 8'hE0,
  parameter logic [(NPRIM+NSEC+2)*NWIN*24-1:0] WIN_MATCH = def_match(),
  parameter logic [(NPRIM+NSEC+2)*NWIN*24-1:0] WIN_MASK  = def_mask(),
  parameter logic [(NPRIM+NSEC+2)*NWIN-1:0]    WIN_EN    = def_en()
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ale,
  input  logic [7:0]       bus_lo_in,
  input  logic [7:0]       bus_hi_in,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             csel_n,
  output logic [7:0]       data_out,
  output logic             data_oe,
  output logic             reg_sel,
  output logic [NPRIM-1:0] prim_sel,
  output logic [NSEC-1:0]  sec_sel,
  output logic             sram_sel
);
  localparam int NSEL = NPRIM + NSEC + 2;
  localparam int SRAM_IDX = NSEL - 1;

  logic [7:0]      lat_lo, lat_hi, page_q;
  logic [AW-1:0]   ext_addr;
  logic [NSEL-1:0] raw_hit, onehot, sel_q;
  logic            page_we, reg_off_hit;

  assign ext_addr    = {page_q, lat_hi, lat_lo};
  assign reg_off_hit = onehot[0] && (lat_lo == PAGE_OFS) && !csel_n;
  assign page_we     = reg_off_hit && !wr_n;

  pgdec_latch #(.DW(8)) i_latch (
    .clk    (clk),
    .rst    (rst),
    .ale    (ale),
    .bus_lo (bus_lo_in),
    .bus_hi (bus_hi_in),
    .page_we(page_we),
    .lat_lo (lat_lo),
    .lat_hi (lat_hi),
    .page_q (page_q)
  );

  for (genvar s = 0; s < NSEL; s++) begin : g_sel
    pgdec_win #(
      .NWIN (NWIN),
      .AW   (AW),
      .MATCH(WIN_MATCH[s*NWIN*AW +: NWIN*AW]),
      .MASK (WIN_MASK [s*NWIN*AW +: NWIN*AW]),
      .EN   (WIN_EN   [s*NWIN +: NWIN])
    ) i_win (
      .addr(ext_addr),
      .hit (raw_hit[s])
    );
  end

  pgdec_prio #(.N(NSEL)) i_prio (
    .req(raw_hit),
    .gnt(onehot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      sel_q    <= csel_n ? '0 : onehot;
      data_oe  <= !csel_n && !rd_n && (|onehot);
      data_out <= (reg_off_hit && !rd_n) ? page_q : 8'h00;
    end
  end

  assign reg_sel  = sel_q[0];
  assign prim_sel = sel_q[NPRIM:1];
  assign sec_sel  = sel_q[NPRIM+NSEC:NPRIM+1];
  assign sram_sel = sel_q[SRAM_IDX];
endmodule

// File: rtl/pgdec_chk.sv
module pgdec_chk #(
  parameter int NPRIM = 8,
  parameter int NSEC  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_n,
  input logic             wr_n,
  input logic             csel_n,
  input logic [7:0]       data_out,
  input logic             data_oe,
  input logic             reg_sel,
  input logic [NPRIM-1:0] prim_sel,
  input logic [NSEC-1:0]  sec_sel,
  input logic             sram_sel,
  input logic [7:0]       page_q
);
  logic [NPRIM+NSEC+1:0] all_sel;
  assign all_sel = {sram_sel, sec_sel, prim_sel, reg_sel};

  a_r9_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(all_sel));

  a_r12_cs_blocks: assert property (@(posedge clk) disable iff (rst)
    csel_n |=> (all_sel == '0 && !data_oe));

  a_r13_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> ((all_sel != '0) && $past(!rd_n)));

  a_r10_page_holds: assert property (@(posedge clk) disable iff (rst)
    wr_n |=> $stable(page_q));

  a_r11_dout_gated: assert property (@(posedge clk) disable iff (rst)
    (data_out != 8'h00) |-> (data_oe && reg_sel));
endmodule

bind pgdec_top pgdec_chk #(.NPRIM(NPRIM), .NSEC(NSEC)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .csel_n  (csel_n),
  .data_out(data_out),
  .data_oe (data_oe),
  .reg_sel (reg_sel),
  .prim_sel(prim_sel),
  .sec_sel (sec_sel),
  .sram_sel(sram_sel),
  .page_q  (page_q)
);

// File: tb/test_pgdec_top.sv
module test_pgdec_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale = 1'b0;
  logic [7:0] bus_lo_in = 8'h00;
  logic [7:0] bus_hi_in = 8'h00;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       csel_n = 1'b0;
  logic [7:0] data_out;
  logic       data_oe;
  logic       reg_sel;
  logic [7:0] prim_sel;
  logic [3:0] sec_sel;
  logic       sram_sel;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  pgdec_top i_pgdec_top (
    .clk(clk), .rst(rst), .ale(ale), .bus_lo_in(bus_lo_in), .bus_hi_in(bus_hi_in),
    .rd_n(rd_n), .wr_n(wr_n), .csel_n(csel_n), .data_out(data_out), .data_oe(data_oe),
    .reg_sel(reg_sel), .prim_sel(prim_sel), .sec_sel(sec_sel), .sram_sel(sram_sel)
  );

  // reference model state
  logic [7:0]  m_page = 8'h00, m_lo = 8'h00, m_hi = 8'h00, m_dout = 8'h00;
  logic [13:0] m_sel = '0;
  logic        m_oe = 1'b0;

  // -1 none, 0 register window, 1..8 primary, 9..12 secondary, 13 SRAM
  function automatic int exp_idx(input logic [7:0] pg, input logic [7:0] hi);
    if (hi == 8'hFF) return 0;
    if ((pg == 8'h00 || pg == 8'h01) && hi < 8'h80) return 1 + int'(hi[6:4]);
    if (hi[7:4] == 4'hF) return 1;
    if (pg == 8'h00 && hi[7:6] == 2'b10) return 9 + int'(hi[5:4]);
    if (hi[7:5] == 3'b110) return 13;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_page = 8'h00; m_lo = 8'h00; m_hi = 8'h00;
      m_sel = '0; m_oe = 1'b0; m_dout = 8'h00;
    end else begin
      int  idx;
      bit  hit;
      bit  regoff;
      idx    = exp_idx(m_page, m_hi);
      hit    = (idx >= 0) && !csel_n;
      regoff = hit && idx == 0 && m_lo == 8'hE0;
      m_sel  = hit ? (14'd1 << idx) : 14'd0;
      m_oe   = hit && !rd_n;
      m_dout = (regoff && !rd_n) ? m_page : 8'h00;
      if (regoff && !wr_n) m_page = bus_lo_in;
      if (ale) begin m_lo = bus_lo_in; m_hi = bus_hi_in; end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    logic [13:0] got;
    got = {sram_sel, sec_sel, prim_sel, reg_sel};
    checks++;
    if (got !== m_sel) begin
      errors++;
      $display("FAIL %s selects got=%b exp=%b", cur_req, got, m_sel);
    end
    checks++;
    if (data_oe !== m_oe) begin
      errors++;
      $display("FAIL %s data_oe got=%b exp=%b", cur_req, data_oe, m_oe);
    end
    checks++;
    if (data_out !== m_dout) begin
      errors++;
      $display("FAIL %s data_out got=%h exp=%h", cur_req, data_out, m_dout);
    end
  end

  task automatic cyc(input string req, input logic [7:0] hi, input logic [7:0] lo,
                     input bit rd, input bit wr, input logic [7:0] wdat, input bit cs_off);
    @(negedge clk);
    cur_req = req;
    ale = 1'b1; bus_hi_in = hi; bus_lo_in = lo; rd_n = 1'b1; wr_n = 1'b1; csel_n = cs_off;
    @(negedge clk);
    ale = 1'b0; bus_lo_in = wr ? wdat : 8'hA5; rd_n = !rd; wr_n = !wr;
    @(negedge clk);
    bus_lo_in = wr ? wdat : 8'h3C;  // R2: bus moves during data phase
    bus_hi_in = ~hi;
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic set_page(input string req, input logic [7:0] p);
    cyc(req, 8'hFF, 8'hE0, 1'b0, 1'b1, p, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    @(negedge clk);
    // R1 / R11: page reads back zero after reset
    cyc("R1", 8'hFF, 8'hE0, 1'b1, 1'b0, 8'h00, 1'b0);
    // R4 primary sectors page 0
    for (int i = 0; i < 8; i++) cyc("R4", 8'(i * 16 + 3), 8'h11, 1'b1, 1'b0, 8'h00, 1'b0);
    // R5 secondary sectors
    for (int j = 0; j < 4; j++) cyc("R5", 8'(8'h80 + j * 16 + 7), 8'h22, 1'b1, 1'b0, 8'h00, 1'b0);
    // R6 SRAM, R7 register window
    cyc("R6", 8'hC4, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R6", 8'hDF, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R7", 8'hFF, 8'h10, 1'b1, 1'b0, 8'h00, 1'b0);
    // R9 overlaps on page 0
    cyc("R9", 8'hF3, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R9", 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
    // R10 / R11: page write and readback
    set_page("R10", 8'h01);
    cyc("R11", 8'hFF, 8'hE0, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R10", 8'hFF, 8'hE1, 1'b0, 1'b1, 8'h77, 1'b0);
    cyc("R10", 8'hFF, 8'hE0, 1'b1, 1'b0, 8'h00, 1'b0);
    // R3 / R8: page 1 repeats primary sectors; secondary region empty here
    cyc("R8", 8'h25, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R3", 8'h84, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R9", 8'h05, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
    // R8: page 2 disabled windows
    set_page("R8", 8'h02);
    cyc("R8", 8'h10, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R8", 8'hF8, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R13", 8'h90, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R13", 8'hC0, 8'h00, 1'b0, 1'b1, 8'h55, 1'b0);
    // R12: chip select off blocks selects and page write
    cyc("R12", 8'hC0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1);
    cyc("R12", 8'hFF, 8'hE0, 1'b0, 1'b1, 8'h99, 1'b1);
    cyc("R12", 8'hFF, 8'hE0, 1'b1, 1'b0, 8'h00, 1'b0);
    // R2 / R14: latch holds across idle clocks with bus noise
    @(negedge clk); cur_req = "R2"; ale = 1'b1; bus_hi_in = 8'hC8; bus_lo_in = 8'h01;
    @(negedge clk); ale = 1'b0; bus_hi_in = 8'h12; bus_lo_in = 8'hE0; rd_n = 1'b0;
    @(negedge clk); cur_req = "R14"; bus_hi_in = 8'hFF;
    @(negedge clk); rd_n = 1'b1;
    // R1: reset mid-run returns page to 0
    @(negedge clk); cur_req = "R1"; rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    cyc("R1", 8'hFF, 8'hE0, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R4", 8'h70, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired got=%0d cycles exp=<20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule